// File: doc/BRIEF.md
# Square Wave Output Generator

This block drives two output pins from a 32768 Hz clock-enable that arrives in the fast system clock domain. Each pin has its own 3-bit mode select. A pin can carry a 50% duty square wave at 1, 32, 64 or 512 Hz, or hold a constant low, or follow the alarm flag. All four wave rates come from one shared binary counter that advances on every enable pulse. Each pin has a registered selector that updates only on an enable pulse, so a pin changes state only in the system clock cycle after a pulse.

The two selects come from the controlling mode word. The neighbour that decodes that word takes the select for pin A from bits 18:16 and the select for pin B from bits 22:20, and hands them to this block as plain 3-bit values. There is no data stream here, only control levels, so the block has no valid/ready handshake. The enable input may be a single-cycle pulse or may be held high on every clock.

Top module: `sqw_gen`

## Requirements
- R1: While reset is active, and after release until the first enable pulse, both wave_a and wave_b are 0. Reset also returns the shared counter to zero, so the count of pulses n restarts from 0.
- R2: Select code 0 drives the pin to 0.
- R3: After the n-th enable pulse since reset, a pin in a wave mode equals one bit of (n mod 32768). Code 1 (1 Hz) uses bit 14, code 2 (32 Hz) bit 9, code 3 (64 Hz) bit 8 and code 4 (512 Hz) bit 5. Each wave therefore has a 50% duty cycle.
- R4: Select code 6 makes the pin equal to the value alarm_flag had in the clock cycle of the most recent enable pulse.
- R5: Reserved select codes 5 and 7 drive the pin to 0.
- R6: A pin changes only in the cycle after an enable pulse. A change of select or alarm_flag while the enable is low has no effect on the pins until the next pulse.
- R7: The two pins are independent. The shared counter keeps counting whatever the selects are, so switching a pin into a wave mode picks up the wave at its running phase.
- R8: With the enable held high on every clock cycle, each cycle counts as one pulse, and R3 still holds cycle by cycle across the counter wrap at 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | 32768 Hz clock-enable, one cycle per pulse |
| sel_a | input | 3 | Mode select for pin A (mode word bits 18:16) |
| sel_b | input | 3 | Mode select for pin B (mode word bits 22:20) |
| alarm_flag | input | 1 | Alarm flag to mirror in mode 6 |
| wave_a | output | 1 | Output pin A |
| wave_b | output | 1 | Output pin B |

## Verification
The bench sweeps all 64 pairs of selects while the counter keeps running. A design with the tap bits swapped, or with a reserved code falling into a wave or alarm leg, therefore gives the wrong level at some pulse. It changes selects and the alarm between pulses and expects no movement until the next pulse; a selector that is not registered would follow the change at once. A long run with the enable held high crosses the 32768 wrap twice, which exposes a 1 Hz tap taken from the wrong bit or a counter that wraps early. A reset in the middle of a run checks that the wave phase restarts from zero and does not carry on from the old count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [2:0] {
    SQW_LOW   = 3'd0,
    SQW_F1    = 3'd1,
    SQW_F32   = 3'd2,
    SQW_F64   = 3'd3,
    SQW_F512  = 3'd4,
    SQW_RSV5  = 3'd5,
    SQW_ALARM = 3'd6,
    SQW_RSV7  = 3'd7
  } sqw_mode_e;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 4;

  // Frequency for each wave tap, in the order of select codes 1..4.
  function automatic int unsigned tap_freq(int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 32;
      2:       return 64;
      default: return 512;
    endcase
  endfunction

  // A counter bit k toggles every 2^k pulses, which gives a period of
  // 2^(k+1) pulses.
  function automatic int unsigned tap_pos(int unsigned src_hz, int unsigned f_hz);
    return $clog2(src_hz / f_hz) - 1;
  endfunction

endpackage

// File: rtl/sqw_divider.sv
module sqw_divider
  import sqw_pkg::*;
#(
  parameter int unsigned SRC_HZ = 32768
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  output logic [NUM_TAPS-1:0] taps_next
);
  localparam int unsigned DIV_W = $clog2(SRC_HZ);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_next;

  assign cnt_next = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt_next;
  end

  // The taps come from the incremented value, so a registered output that
  // loads on a pulse lines up with the counter after that same pulse.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned POS = tap_pos(SRC_HZ, tap_freq(i));
    assign taps_next[i] = cnt_next[POS];
  end

endmodule

// File: rtl/sqw_out_mux.sv
module sqw_out_mux
  import sqw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TAPS-1:0] taps_next,
  input  logic                alarm,
  output logic                wave
);
  logic wave_d;

  always_comb begin
    unique case (sqw_mode_e'(sel))
      SQW_F1:    wave_d = taps_next[0];
      SQW_F32:   wave_d = taps_next[1];
      SQW_F64:   wave_d = taps_next[2];
      SQW_F512:  wave_d = taps_next[3];
      SQW_ALARM: wave_d = alarm;
      default:   wave_d = 1'b0;
    endcase
  end

  // Loading only on a pulse keeps every level at least one pulse long.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wave <= 1'b0;
    else if (tick) wave <= wave_d;
  end

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned SRC_HZ  = 32768,
  parameter int unsigned NUM_OUT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic       alarm_flag,
  output logic       wave_a,
  output logic       wave_b
);
  logic [NUM_TAPS-1:0]           taps_next;
  logic [NUM_OUT-1:0][SEL_W-1:0] sel_vec;
  logic [NUM_OUT-1:0]            wave_vec;

  assign sel_vec[0] = sel_a;
  assign sel_vec[1] = sel_b;

  sqw_divider #(.SRC_HZ(SRC_HZ)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_32k),
    .taps_next (taps_next)
  );

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    sqw_out_mux u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_32k),
      .sel       (sel_vec[j]),
      .taps_next (taps_next),
      .alarm     (alarm_flag),
      .wave      (wave_vec[j])
    );
  end

  assign wave_a = wave_vec[0];
  assign wave_b = wave_vec[1];

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_32k,
  input logic [2:0] sel_a,
  input logic [2:0] sel_b,
  input logic       alarm_flag,
  input logic       wave_a,
  input logic       wave_b
);
  assert_low_mode_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && sel_a == 3'd0) |=> !wave_a);
  assert_low_mode_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && sel_b == 3'd0) |=> !wave_b);

  assert_alarm_copy_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && sel_a == 3'd6) |=> (wave_a == $past(alarm_flag)));
  assert_alarm_copy_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && sel_b == 3'd6) |=> (wave_b == $past(alarm_flag)));

  assert_reserved_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && (sel_a == 3'd5 || sel_a == 3'd7)) |=> !wave_a);
  assert_reserved_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_32k && (sel_b == 3'd5 || sel_b == 3'd7)) |=> !wave_b);

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_32k |=> ($stable(wave_a) && $stable(wave_b)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (!wave_a && !wave_b);
    end
  end
endmodule

bind sqw_gen sqw_gen_chk i_sqw_gen_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_32k   (tick_32k),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .alarm_flag (alarm_flag),
  .wave_a     (wave_a),
  .wave_b     (wave_b)
);

// File: tb/test_sqw_gen.sv
module test_sqw_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [2:0] sel_a = 3'd0;
  logic [2:0] sel_b = 3'd0;
  logic       alarm_flag = 1'b0;
  logic       wave_a;
  logic       wave_b;

  int  n_chk = 0;
  int  n_fail = 0;
  int  n_tick = 0;
  bit  al_seen = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  sqw_gen i_sqw_gen (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .sel_a(sel_a), .sel_b(sel_b), .alarm_flag(alarm_flag),
    .wave_a(wave_a), .wave_b(wave_b)
  );

  function automatic bit exp_wave(logic [2:0] m, int n, bit al);
    int c = n % 32768;
    case (m)
      3'd1: return c[14];
      3'd2: return c[9];
      3'd3: return c[8];
      3'd4: return c[5];
      3'd6: return al;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd6: return "R4";
      3'd5, 3'd7: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b (pulse %0d)", req, what, got, exp, n_tick);
    end
  endtask

  task automatic check_both(string tag);
    check(wave_a, exp_wave(sel_a, n_tick, al_seen), req_of(sel_a), {tag, " pin A"});
    check(wave_b, exp_wave(sel_b, n_tick, al_seen), req_of(sel_b), {tag, " pin B"});
  endtask

  // One enable pulse; the pins are checked at the following falling edge.
  task automatic pulse(string tag);
    tick_32k = 1'b1;
    al_seen  = alarm_flag;
    @(posedge clk);
    n_tick++;
    @(negedge clk);
    tick_32k = 1'b0;
    check_both(tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(wave_a, 1'b0, "R1", "reset pin A");
    check(wave_b, 1'b0, "R1", "reset pin B");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(wave_a, 1'b0, "R1", "released, no pulse, pin A");
    check(wave_b, 1'b0, "R1", "released, no pulse, pin B");

    // Sweep of all select pairs over a running counter (R2..R5, R7).
    for (int sa = 0; sa < 8; sa++) begin
      for (int sb = 0; sb < 8; sb++) begin
        sel_a = 3'(sa);
        sel_b = 3'(sb);
        for (int k = 0; k < 40; k++) begin
          alarm_flag = 1'(((n_tick * 7) >> 2) & 1);
          pulse("R7 sweep");
          @(negedge clk);
        end
      end
    end

    // Changes between pulses must not reach the pins (R6).
    for (int r = 0; r < 8; r++) begin
      bit ha, hb;
      sel_a = 3'd6; sel_b = 3'd4;
      alarm_flag = 1'(r & 1);
      pulse("R6 setup");
      ha = wave_a; hb = wave_b;
      sel_a = 3'(r); sel_b = 3'(7 - r);
      alarm_flag = ~alarm_flag;
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        check(wave_a, ha, "R6", "hold between pulses pin A");
        check(wave_b, hb, "R6", "hold between pulses pin B");
      end
      pulse("R6 after pulse");
    end

    // Enable held high on every cycle, crossing the wrap (R8, R3).
    sel_a = 3'd1; sel_b = 3'd4;
    tick_32k = 1'b1;
    for (int c = 0; c < 70000; c++) begin
      if (c == 40000) sel_b = 3'd2;
      if (c == 55000) sel_b = 3'd3;
      al_seen = alarm_flag;
      @(posedge clk);
      n_tick++;
      @(negedge clk);
      check(wave_a, exp_wave(sel_a, n_tick, al_seen), "R8", "continuous 1 Hz pin A");
      check(wave_b, exp_wave(sel_b, n_tick, al_seen), "R8", "continuous pin B");
    end
    tick_32k = 1'b0;

    // Reset in the middle of a run restarts the phase (R1).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(wave_a, 1'b0, "R1", "mid-run reset pin A");
    check(wave_b, 1'b0, "R1", "mid-run reset pin B");
    rst_n = 1'b1;
    n_tick = 0;
    sel_a = 3'd4; sel_b = 3'd0;
    for (int k = 0; k < 70; k++) begin
      pulse("R1 phase restart");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule